// File: doc/BRIEF.md
# Single-Bank DRAM Page-Policy Sequencer

This block sits between a request source and one DRAM bank. It takes one request at a time, each a read or a write of a single 64-byte burst. For each request it issues the precharge, activate and column commands the bank needs, and it keeps the required number of cycles between them. Each command is a one-cycle pulse on `cmd`. The row number goes out on `cmd_row` and the burst slot within the row goes out on `cmd_col`. Every activate loads one whole 8 KB row into the bank's row buffer. A column command then picks one 64-byte burst out of that row.

A mode bit is sampled with each request and sets the page policy for that request. In open-page mode the row stays in the row buffer after the access. A later request to the same row then goes straight to the column command. A request to a different row first closes the old row with a precharge, then activates the new row. In closed-page mode the sequencer precharges as soon as the column phase ends, so the next access always starts from a closed bank.

The block tracks whether a row is open and which row it is. It counts requests that found their row already open (hits) and requests that did not (misses). A `done` pulse marks the end of each column phase.

Top module: `dram_page_ctrl`

## Requirements
- R1: After reset `req_ready` is 1, `row_open` is 0, both counters are 0, `done` is 0 and `cmd` is NOP (code 0).
- R2: The row is `req_addr >> 13` and the column slot is `req_addr[12:6]`. Command codes are NOP=0, PRE=1, ACT=2, RD=3, WR=4. The column command is RD for a read and WR for a write, and `cmd_row` and `cmd_col` carry the request's row and slot when ACT or a column command is issued.
- R3: With no row open, a request issues ACT in the cycle after acceptance and the column command 5 cycles later, with no PRE before them.
- R4: A request whose row is already open issues the column command in the cycle after acceptance, with no PRE and no ACT, in either mode.
- R5: A request to a row other than the open one issues PRE in the cycle after acceptance, ACT 5 cycles later and the column command 5 cycles after that.
- R6: `done` pulses for one cycle, 4 cycles after the column command.
- R7: In open-page mode `req_ready` returns to 1 in the same cycle that `done` pulses, and the row stays open.
- R8: In closed-page mode PRE is issued in the same cycle that `done` pulses, and `req_ready` returns to 1 five cycles later with `row_open` at 0.
- R9: The hit counter goes up by one for each accepted request whose row was open. Every other accepted request adds one to the miss counter.
- R10: While `req_ready` is 0, `req_valid` is ignored. No command, counter change or open-row change comes from it.
- R11: The mode bit is sampled per request, so switching modes between requests takes effect on the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| close_mode | input | 1 | 1 = closed-page policy, 0 = open-page policy; sampled on acceptance |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Byte address of the 64-byte burst |
| req_ready | output | 1 | Sequencer idle and able to accept |
| cmd | output | 3 | Command pulse: 0 NOP, 1 PRE, 2 ACT, 3 RD, 4 WR |
| cmd_row | output | 11 | Row targeted by the current PRE or ACT |
| cmd_col | output | 7 | 64-byte slot within the row for the column command |
| done | output | 1 | One-cycle pulse at the end of the column phase |
| row_open | output | 1 | A row is held in the row buffer |
| open_row | output | 11 | Row held in the row buffer |
| hit_count | output | 16 | Accepted requests that found their row open |
| miss_count | output | 16 | Accepted requests that did not |

## Verification
The bench goes after the first access after reset. A design that always precharges first would show PRE at step 0 and finish five cycles late. It checks a hit right after a switch from open to closed mode. A design that tied the policy to row state instead of sampling the mode per request would either skip the trailing precharge or reactivate a row that is already open. It holds `req_valid` high during a busy window with a different row. A design that accepted it would start a second command sequence, change `open_row` and add an extra miss. Finally it checks a conflict at the highest address. A design that sliced the row or slot bits wrongly would put the wrong values on `cmd_row` and `cmd_col`.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_PRE = 3'd1,
    CMD_ACT = 3'd2,
    CMD_RD  = 3'd3,
    CMD_WR  = 3'd4
  } dram_cmd_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_CLOSE_OLD,
    SQ_OPEN,
    SQ_COLUMN,
    SQ_CLOSE_AFTER
  } seq_state_e;

endpackage

// File: rtl/dpc_addr_split.sv
module dpc_addr_split #(
  parameter int ADDR_W      = 24,
  parameter int ROW_BYTES   = 8192,
  parameter int BURST_BYTES = 64,
  localparam int ROW_SH = $clog2(ROW_BYTES),
  localparam int COL_SH = $clog2(BURST_BYTES),
  localparam int ROW_W  = ADDR_W - ROW_SH,
  localparam int COL_W  = ROW_SH - COL_SH
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              row_open,
  input  logic [ROW_W-1:0]  open_row,
  output logic [ROW_W-1:0]  row,
  output logic [COL_W-1:0]  col,
  output logic              hit,
  output logic              conflict
);

  always_comb begin
    row      = addr[ADDR_W-1:ROW_SH];
    col      = addr[ROW_SH-1:COL_SH];
    hit      = row_open && (open_row == row);
    conflict = row_open && (open_row != row);
  end

endmodule

// File: rtl/dpc_phase_timer.sv
module dpc_phase_timer #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/dpc_stat_counter.sv
module dpc_stat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);

  logic [W-1:0] cnt_q;
  logic         cnt_en;

  always_comb begin
    cnt_en = inc && (cnt_q != {W{1'b1}});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign count = cnt_q;

endmodule

// File: rtl/dram_page_ctrl.sv
module dram_page_ctrl
  import dpc_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int ROW_BYTES   = 8192,
  parameter int BURST_BYTES = 64,
  parameter int T_PRE       = 5,
  parameter int T_ACT       = 5,
  parameter int T_COL       = 4,
  parameter int CNT_W       = 16,
  localparam int ROW_SH = $clog2(ROW_BYTES),
  localparam int COL_SH = $clog2(BURST_BYTES),
  localparam int ROW_W  = ADDR_W - ROW_SH,
  localparam int COL_W  = ROW_SH - COL_SH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              close_mode,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic [2:0]        cmd,
  output logic [ROW_W-1:0]  cmd_row,
  output logic [COL_W-1:0]  cmd_col,
  output logic              done,
  output logic              row_open,
  output logic [ROW_W-1:0]  open_row,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count
);

  localparam int T_MAX12 = (T_PRE > T_ACT) ? T_PRE : T_ACT;
  localparam int T_MAX   = (T_MAX12 > T_COL) ? T_MAX12 : T_COL;
  localparam int TW      = $clog2(T_MAX + 1);
  localparam logic [TW-1:0] LD_PRE = TW'(T_PRE - 1);
  localparam logic [TW-1:0] LD_ACT = TW'(T_ACT - 1);
  localparam logic [TW-1:0] LD_COL = TW'(T_COL - 1);
  localparam int N_STAT  = 2;

  // request decode
  logic [ROW_W-1:0] in_row;
  logic [COL_W-1:0] in_col;
  logic             in_hit;
  logic             in_conflict;

  // state
  seq_state_e       state_q, state_d;
  dram_cmd_e        cmd_q, cmd_d;
  logic [ROW_W-1:0] cmd_row_q, cmd_row_d;
  logic             done_q, done_d;
  logic             open_q, open_d;
  logic [ROW_W-1:0] open_row_q, open_row_d;
  logic             wr_q, closed_q;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;

  logic             accept;
  logic             tmr_load;
  logic [TW-1:0]    tmr_val;
  logic             tmr_expired;
  logic [N_STAT-1:0] stat_inc;
  logic [CNT_W-1:0] stat_cnt [N_STAT];

  dpc_addr_split #(
    .ADDR_W     (ADDR_W),
    .ROW_BYTES  (ROW_BYTES),
    .BURST_BYTES(BURST_BYTES)
  ) u_split (
    .addr     (req_addr),
    .row_open (open_q),
    .open_row (open_row_q),
    .row      (in_row),
    .col      (in_col),
    .hit      (in_hit),
    .conflict (in_conflict)
  );

  dpc_phase_timer #(.W(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  // index 0 counts hits, index 1 counts misses
  for (genvar gi = 0; gi < N_STAT; gi++) begin : g_stat
    dpc_stat_counter #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (stat_inc[gi]),
      .count (stat_cnt[gi])
    );
  end

  assign req_ready = (state_q == SQ_IDLE);
  assign accept    = req_valid && req_ready;

  always_comb begin
    state_d    = state_q;
    cmd_d      = CMD_NOP;
    cmd_row_d  = cmd_row_q;
    done_d     = 1'b0;
    open_d     = open_q;
    open_row_d = open_row_q;
    tmr_load   = 1'b0;
    tmr_val    = '0;
    stat_inc   = '0;

    unique case (state_q)
      SQ_IDLE: begin
        if (accept) begin
          stat_inc[0] = in_hit;
          stat_inc[1] = !in_hit;
          tmr_load    = 1'b1;
          if (in_hit) begin
            state_d = SQ_COLUMN;
            tmr_val = LD_COL;
            cmd_d   = req_write ? CMD_WR : CMD_RD;
          end else if (in_conflict) begin
            state_d   = SQ_CLOSE_OLD;
            tmr_val   = LD_PRE;
            cmd_d     = CMD_PRE;
            cmd_row_d = open_row_q;
            open_d    = 1'b0;
          end else begin
            state_d    = SQ_OPEN;
            tmr_val    = LD_ACT;
            cmd_d      = CMD_ACT;
            cmd_row_d  = in_row;
            open_d     = 1'b1;
            open_row_d = in_row;
          end
        end
      end
      SQ_CLOSE_OLD: begin
        if (tmr_expired) begin
          state_d    = SQ_OPEN;
          tmr_load   = 1'b1;
          tmr_val    = LD_ACT;
          cmd_d      = CMD_ACT;
          cmd_row_d  = row_q;
          open_d     = 1'b1;
          open_row_d = row_q;
        end
      end
      SQ_OPEN: begin
        if (tmr_expired) begin
          state_d  = SQ_COLUMN;
          tmr_load = 1'b1;
          tmr_val  = LD_COL;
          cmd_d    = wr_q ? CMD_WR : CMD_RD;
        end
      end
      SQ_COLUMN: begin
        if (tmr_expired) begin
          done_d = 1'b1;
          if (closed_q) begin
            state_d   = SQ_CLOSE_AFTER;
            tmr_load  = 1'b1;
            tmr_val   = LD_PRE;
            cmd_d     = CMD_PRE;
            cmd_row_d = row_q;
            open_d    = 1'b0;
          end else begin
            state_d = SQ_IDLE;
          end
        end
      end
      SQ_CLOSE_AFTER: begin
        if (tmr_expired) begin
          state_d = SQ_IDLE;
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= SQ_IDLE;
      cmd_q      <= CMD_NOP;
      cmd_row_q  <= '0;
      done_q     <= 1'b0;
      open_q     <= 1'b0;
      open_row_q <= '0;
    end else begin
      state_q    <= state_d;
      cmd_q      <= cmd_d;
      cmd_row_q  <= cmd_row_d;
      done_q     <= done_d;
      open_q     <= open_d;
      open_row_q <= open_row_d;
    end
  end

  // request capture, enabled on acceptance only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q     <= 1'b0;
      closed_q <= 1'b0;
      row_q    <= '0;
      col_q    <= '0;
    end else if (accept) begin
      wr_q     <= req_write;
      closed_q <= close_mode;
      row_q    <= in_row;
      col_q    <= in_col;
    end
  end

  assign cmd        = cmd_q;
  assign cmd_row    = cmd_row_q;
  assign cmd_col    = col_q;
  assign done       = done_q;
  assign row_open   = open_q;
  assign open_row   = open_row_q;
  assign hit_count  = stat_cnt[0];
  assign miss_count = stat_cnt[1];

endmodule

// File: rtl/dpc_checker.sv
module dpc_checker #(
  parameter int ROW_W = 11,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [2:0]       cmd,
  input logic             done,
  input logic             row_open,
  input logic [CNT_W-1:0] hit_count,
  input logic [CNT_W-1:0] miss_count
);

  // R1: while idle the command bus stays quiet
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (cmd == 3'd0));

  // R10: an accepted request makes the sequencer busy for the next cycle
  a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R3: every acceptance launches a command in the following cycle
  a_r3_accept_issues_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (cmd != 3'd0));

  // R6: done lasts one cycle
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5: activate leaves a row open, precharge leaves none
  a_r5_act_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'd2) |-> row_open);
  a_r8_pre_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'd1) |-> !row_open);

  // R9: counters move only right after an acceptance, and together by one
  a_r9_count_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    ((hit_count != $past(hit_count)) || (miss_count != $past(miss_count)))
      |-> $past(req_valid && req_ready));
  a_r9_one_counter: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && req_ready) |->
      ((hit_count - $past(hit_count)) + (miss_count - $past(miss_count)) == CNT_W'(1)));

endmodule

bind dram_page_ctrl dpc_checker #(.ROW_W(ROW_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .cmd        (cmd),
  .done       (done),
  .row_open   (row_open),
  .hit_count  (hit_count),
  .miss_count (miss_count)
);

// File: tb/tb_dram_page_ctrl.sv
`timescale 1ns/1ps
module tb_dram_page_ctrl;

  logic        clk;
  logic        rst_n;
  logic        close_mode;
  logic        req_valid;
  logic        req_write;
  logic [23:0] req_addr;
  logic        req_ready;
  logic [2:0]  cmd;
  logic [10:0] cmd_row;
  logic [6:0]  cmd_col;
  logic        done;
  logic        row_open;
  logic [10:0] open_row;
  logic [15:0] hit_count;
  logic [15:0] miss_count;

  int n_tests = 0;
  int n_fail  = 0;

  dram_page_ctrl dut (
    .clk(clk), .rst_n(rst_n), .close_mode(close_mode),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_ready(req_ready), .cmd(cmd), .cmd_row(cmd_row), .cmd_col(cmd_col),
    .done(done), .row_open(row_open), .open_row(open_row),
    .hit_count(hit_count), .miss_count(miss_count)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Issues one request and records the step of each event; step 0 is the
  // cycle right after acceptance. -1 means the event never occurred.
  task automatic run_access(input bit wr, input int addr, input bit closed,
                            input int e_pre, input int e_act, input int e_col,
                            input int e_done, input int e_tpre, input int e_rdy,
                            input string tag, input bit poke);
    int s_pre = -1, s_act = -1, s_col = -1, s_done = -1, s_tpre = -1, s_rdy = -1;
    int exp_row = addr >> 13;
    int exp_col = (addr >> 6) & 127;
    @(negedge clk);
    chk(req_ready == 1'b1, {tag, " R10 ready before request"}, int'(req_ready), 1);
    req_valid  = 1'b1;
    req_write  = wr;
    req_addr   = 24'(addr);
    close_mode = closed;
    @(negedge clk);
    req_valid = 1'b0;
    for (int step = 0; step < 40; step++) begin
      if (cmd == 3'd1) begin
        if (s_col < 0) s_pre = step; else s_tpre = step;
      end
      if (cmd == 3'd2) begin
        s_act = step;
        chk(int'(cmd_row) == exp_row, {tag, " R2 row on ACT"}, int'(cmd_row), exp_row);
      end
      if (cmd == 3'd3 || cmd == 3'd4) begin
        s_col = step;
        chk(int'(cmd) == (wr ? 4 : 3), {tag, " R2 column code"}, int'(cmd), wr ? 4 : 3);
        chk(int'(cmd_col) == exp_col, {tag, " R2 column slot"}, int'(cmd_col), exp_col);
      end
      if (done) s_done = step;
      if (req_ready) begin
        s_rdy = step;
        break;
      end
      if (poke && step == 1) begin
        req_valid = 1'b1;
        req_addr  = 24'(9 << 13);
        req_write = 1'b0;
      end
      if (poke && step == 3) req_valid = 1'b0;
      @(negedge clk);
    end
    chk(s_pre == e_pre, {tag, " R5 precharge step"}, s_pre, e_pre);
    chk(s_act == e_act, {tag, " R3 activate step"}, s_act, e_act);
    chk(s_col == e_col, {tag, " R4 column step"}, s_col, e_col);
    chk(s_done == e_done, {tag, " R6 done step"}, s_done, e_done);
    chk(s_tpre == e_tpre, {tag, " R8 trailing precharge step"}, s_tpre, e_tpre);
    chk(s_rdy == e_rdy, {tag, " R7 ready step"}, s_rdy, e_rdy);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
    chk(row_open == 1'b0, "R1 row_open", int'(row_open), 0);
    chk(hit_count == 0 && miss_count == 0, "R1 counters", int'(hit_count + miss_count), 0);
    chk(cmd == 3'd0 && done == 1'b0, "R1 cmd and done", int'(cmd), 0);
  endtask

  task automatic t_first_open();
    run_access(1'b0, 32'h12340, 1'b0, -1, 0, 5, 9, -1, 9, "first", 1'b0);
    chk(row_open && open_row == 11'd9, "R7 row kept open", int'(open_row), 9);
    chk(miss_count == 1, "R9 first miss", int'(miss_count), 1);
  endtask

  task automatic t_open_hit();
    run_access(1'b1, 9 * 8192 + 64 * 100, 1'b0, -1, -1, 0, 4, -1, 4, "hit", 1'b0);
    chk(hit_count == 1, "R9 hit counted", int'(hit_count), 1);
  endtask

  task automatic t_conflict_poke();
    run_access(1'b0, 20 * 8192 + 64 * 5, 1'b0, 0, 5, 10, 14, -1, 14, "conflict", 1'b1);
    chk(open_row == 11'd20, "R10 open row untouched by ignored request", int'(open_row), 20);
    chk(miss_count == 2 && hit_count == 1, "R10 counters untouched",
        int'(miss_count), 2);
    @(negedge clk);
    chk(cmd == 3'd0, "R10 no command from ignored request", int'(cmd), 0);
  endtask

  task automatic t_mode_switch_hit();
    run_access(1'b0, 20 * 8192 + 64 * 7, 1'b1, -1, -1, 0, 4, 4, 9, "switch", 1'b0);
    chk(row_open == 1'b0, "R11 closed after switched hit", int'(row_open), 0);
    chk(hit_count == 2, "R11 hit under closed mode", int'(hit_count), 2);
  endtask

  task automatic t_closed_pair();
    run_access(1'b1, 3 * 8192, 1'b1, -1, 0, 5, 9, 9, 14, "closedA", 1'b0);
    chk(row_open == 1'b0, "R8 row closed", int'(row_open), 0);
    run_access(1'b0, 3 * 8192 + 64, 1'b1, -1, 0, 5, 9, 9, 14, "closedB", 1'b0);
    chk(miss_count == 4, "R9 closed repeats miss", int'(miss_count), 4);
  endtask

  task automatic t_back_to_open();
    run_access(1'b0, 3 * 8192 + 128, 1'b0, -1, 0, 5, 9, -1, 9, "reopen", 1'b0);
    chk(row_open == 1'b1, "R11 open mode keeps row", int'(row_open), 1);
    run_access(1'b1, 24'hFFFFC0, 1'b0, 0, 5, 10, 14, -1, 14, "top", 1'b0);
    chk(open_row == 11'h7FF, "R2 top row", int'(open_row), 2047);
    chk(miss_count == 6 && hit_count == 2, "R9 final counts", int'(miss_count), 6);
  endtask

  initial begin
    rst_n      = 1'b0;
    close_mode = 1'b0;
    req_valid  = 1'b0;
    req_write  = 1'b0;
    req_addr   = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_first_open();
    t_open_hit();
    t_conflict_poke();
    t_mode_switch_hit();
    t_closed_pair();
    t_back_to_open();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule